// File: doc/BRIEF.md
# ADC Result Register Arbiter

This block is the digital wrapper that sits between a 10-bit successive-approximation converter core and the CPU bus. The core signals the end of each conversion with a one-cycle strobe and a 10-bit value. The block keeps that value in a result register. The CPU sees the register in two forms: a 16-bit left-aligned view and an 8-bit view of the upper bits. The block also holds an 8-bit mode register. Bit 7 of that register starts and stops conversions, and bit 0 enables the comparator. Both bits are driven out to the core.

The block settles what happens when a hardware update and a CPU access fall in the same cycle. A result read always returns the value held before the update. The new value waits in a one-entry buffer and is committed on the first cycle with no result read. A mode-register write that meets a conversion end discards that conversion completely. Every commit produces a one-cycle conversion-complete interrupt.

Bus decoding is fixed. Address 0 is the full view, address 1 is the upper-byte view, address 2 is the mode register, and address 3 is unused. Read data is combinational and is valid in the same cycle as the read strobe.

Top module: `adc_result_arbiter`

## Requirements
- R1: Reset (rst_n low at a clock edge) clears the result register, the mode register and any deferred update. After reset, a read at any address returns 0, and conv_irq, conv_start and conv_enable are 0.
- R2: A read at address 0 returns the 10-bit result in bits 15:6. Bits 5:0 read as zero.
- R3: A read at address 1 returns result bits 9:2 in bits 7:0. Bits 15:8 read as zero.
- R4: A write at address 2 stores all 8 data bits, and a read at address 2 returns them in bits 7:0. conv_start follows mode bit 7 and conv_enable follows mode bit 0. The mode register changes only on a write at address 2.
- R5: The strobe is accepted when mode bit 7 is set and there is no mode write and no result read in that cycle. The next clock edge then loads the strobe's value. In the following cycle conv_irq is high and the new value is readable.
- R6: A strobe that arrives while mode bit 7 is clear is ignored. The result does not change and no interrupt is raised.
- R7: A strobe that arrives in a cycle with a read at address 0 or 1 does not disturb that read, which returns the old value. The value is held and committed at the edge that ends the first cycle with no result read. conv_irq goes high in the cycle after that edge.
- R8: If a new strobe is accepted while an earlier value is still deferred, the newer value replaces the older one. Only one interrupt is raised for both.
- R9: A strobe that coincides with a write at address 2 is discarded. The result register is not updated and no interrupt is raised for it.
- R10: Writes at addresses 0, 1 and 3 have no effect, and a read at address 3 returns 0.
- R11: conv_irq is high for exactly one cycle per commit. The result register changes only in cycles where conv_irq is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eoc_strobe | input | 1 | One-cycle end-of-conversion pulse from the converter core |
| eoc_result | input | 10 | Conversion value, valid with eoc_strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register select: 0 full view, 1 upper byte, 2 mode |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Combinational read data, zero when bus_rd is low |
| conv_start | output | 1 | Mode bit 7, conversion start/stop |
| conv_enable | output | 1 | Mode bit 0, comparator enable |
| conv_irq | output | 1 | One-cycle conversion-complete interrupt |

## Verification
Some properties are checked by assertions on every cycle:
- the result register moves only in interrupt cycles;
- no interrupt follows a cycle that held a result read;
- the deferred buffer is empty after any cycle with no read;
- a strobe dropped by a mode write, or by a cleared start bit, raises no interrupt;
- the mode register holds its value without a write.

Other behaviour can only be shown by the bench's scenarios, because it depends on the values that come out. These are the arithmetic of both views over every 10-bit result, the old value returned on a colliding read, the newest value winning after a held read, and the mode readback over all 256 codes.

// File: rtl/adc_arb_pkg.sv
// Package: shared register-select encoding for the ADC result arbiter.
// Assumes a 2-bit bus address; the codes are fixed because software decodes them.
package adc_arb_pkg;

    typedef enum logic [1:0] {
        SEL_FULL  = 2'd0,   // result, left-aligned 16-bit view
        SEL_UPPER = 2'd1,   // result upper bits, 8-bit view
        SEL_MODE  = 2'd2,   // mode register
        SEL_NONE  = 2'd3    // unused
    } reg_sel_e;

endpackage

// File: rtl/adc_mode_reg.sv
// Module: adc_mode_reg
// Holds the converter mode byte. Loads on a decoded write and is otherwise static.
// Assumes the caller has already decoded the address into wr_en.
module adc_mode_reg #(
    parameter int MODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wdata,
    output logic [MODE_W-1:0] mode_q
);

    // Load the mode byte on write; synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (wr_en)
            mode_q <= wdata;
    end

    // R4
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mode_q));

endmodule

// File: rtl/adc_result_commit.sv
// Module: adc_result_commit
// Accepts end-of-conversion values and commits them to the result register.
// A value that meets a result read is held in a one-entry buffer. A value that
// meets a mode write, or that arrives while start is off, is dropped.
// irq_q pulses in the cycle after each commit edge.
// Assumes res_read and mode_wr are already decoded and never both high.
module adc_result_commit #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eoc,
    input  logic [RES_W-1:0] eoc_data,
    input  logic             start_on,
    input  logic             mode_wr,
    input  logic             res_read,
    output logic [RES_W-1:0] result_q,
    output logic             irq_q
);

    logic             accept;
    logic             pend_v;
    logic [RES_W-1:0] pend_d;
    logic             cand_v;
    logic [RES_W-1:0] cand_d;

    // Choose the value waiting to be committed: a fresh strobe beats the buffer.
    always_comb begin
        accept = eoc && start_on && !mode_wr;
        cand_v = accept || pend_v;
        cand_d = accept ? eoc_data : pend_d;
    end

    // Commit when the result is not being read, otherwise defer into the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            pend_v   <= 1'b0;
            pend_d   <= '0;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= cand_v && !res_read;
            if (cand_v) begin
                if (res_read) begin
                    pend_v <= 1'b1;
                    pend_d <= cand_d;
                end else begin
                    result_q <= cand_d;
                    pend_v   <= 1'b0;
                end
            end
        end
    end

    // R11
    result_moves_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_q |-> $stable(result_q));

    // R7
    no_irq_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> !$past(res_read));

    // R7
    pend_empty_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(res_read) |-> !pend_v);

    // R9
    mode_clash_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && eoc && !pend_v) |=> !irq_q);

    // R6
    stopped_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_on && eoc && !pend_v) |=> !irq_q);

endmodule

// File: rtl/adc_read_mux.sv
// Module: adc_read_mux
// Combinational read data for the bus: full left-aligned view, upper-byte view,
// or mode byte. Returns zero when no read is in progress or the address is unused.
// Assumes RES_W <= BUS_W, BYTE_W <= RES_W and MODE_W <= BUS_W.
module adc_read_mux
    import adc_arb_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int BUS_W  = 16,
    parameter int BYTE_W = 8,
    parameter int MODE_W = 8
) (
    input  logic              rd_en,
    input  reg_sel_e          sel,
    input  logic [RES_W-1:0]  result,
    input  logic [MODE_W-1:0] mode,
    output logic [BUS_W-1:0]  rdata
);

    localparam int FULL_PAD  = BUS_W - RES_W;
    localparam int UPPER_PAD = BUS_W - BYTE_W;
    localparam int MODE_PAD  = BUS_W - MODE_W;

    logic [BUS_W-1:0] full_view;
    logic [BUS_W-1:0] upper_view;
    logic [BUS_W-1:0] mode_view;

    // Build each view at bus width.
    generate
        if (FULL_PAD > 0) begin : g_full_pad
            assign full_view = {result, {FULL_PAD{1'b0}}};
        end else begin : g_full_flat
            assign full_view = result;
        end
        if (UPPER_PAD > 0) begin : g_upper_pad
            assign upper_view = {{UPPER_PAD{1'b0}}, result[RES_W-1 -: BYTE_W]};
        end else begin : g_upper_flat
            assign upper_view = result[RES_W-1 -: BYTE_W];
        end
        if (MODE_PAD > 0) begin : g_mode_pad
            assign mode_view = {{MODE_PAD{1'b0}}, mode};
        end else begin : g_mode_flat
            assign mode_view = mode;
        end
    endgenerate

    // Select the addressed view while a read is active.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_FULL:  rdata = full_view;
                SEL_UPPER: rdata = upper_view;
                SEL_MODE:  rdata = mode_view;
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/adc_result_arbiter.sv
// Module: adc_result_arbiter (top)
// Decodes the bus into result reads and mode writes, keeps the mode byte, and
// arbitrates converter result updates against CPU accesses.
// Assumes a single-cycle bus with combinational read data, and that the
// converter core delivers one-cycle end-of-conversion strobes.
module adc_result_arbiter
    import adc_arb_pkg::*;
#(
    parameter int RES_W     = 10,
    parameter int BUS_W     = 16,
    parameter int BYTE_W    = 8,
    parameter int MODE_W    = 8,
    parameter int START_BIT = 7,
    parameter int EN_BIT    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eoc_strobe,
    input  logic [RES_W-1:0]  eoc_result,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              conv_start,
    output logic              conv_enable,
    output logic              conv_irq
);

    reg_sel_e          sel;
    logic              res_read;
    logic              mode_wr;
    logic [MODE_W-1:0] mode_q;
    logic [RES_W-1:0]  result_q;

    // Decode the bus strobes into result-read and mode-write events.
    always_comb begin
        sel      = reg_sel_e'(bus_addr);
        res_read = bus_rd && ((sel == SEL_FULL) || (sel == SEL_UPPER));
        mode_wr  = bus_wr && (sel == SEL_MODE);
    end

    adc_mode_reg #(.MODE_W(MODE_W)) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (mode_wr),
        .wdata  (bus_wdata),
        .mode_q (mode_q)
    );

    adc_result_commit #(.RES_W(RES_W)) u_commit (
        .clk      (clk),
        .rst_n    (rst_n),
        .eoc      (eoc_strobe),
        .eoc_data (eoc_result),
        .start_on (mode_q[START_BIT]),
        .mode_wr  (mode_wr),
        .res_read (res_read),
        .result_q (result_q),
        .irq_q    (conv_irq)
    );

    adc_read_mux #(
        .RES_W  (RES_W),
        .BUS_W  (BUS_W),
        .BYTE_W (BYTE_W),
        .MODE_W (MODE_W)
    ) u_mux (
        .rd_en  (bus_rd),
        .sel    (sel),
        .result (result_q),
        .mode   (mode_q),
        .rdata  (bus_rdata)
    );

    // Drive the control bits to the converter core.
    always_comb begin
        conv_start  = mode_q[START_BIT];
        conv_enable = mode_q[EN_BIT];
    end

endmodule

// File: tb/adc_result_arbiter_test.sv
`timescale 1ns/1ps
module adc_result_arbiter_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        eoc_strobe;
    logic [9:0]  eoc_result;
    logic        bus_rd;
    logic        bus_wr;
    logic [1:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic [15:0] bus_rdata;
    logic        conv_start;
    logic        conv_enable;
    logic        conv_irq;

    int checks = 0;
    int errors = 0;
    int irq_count = 0;
    logic irq_seen = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    adc_result_arbiter uut (
        .clk(clk), .rst_n(rst_n), .eoc_strobe(eoc_strobe), .eoc_result(eoc_result),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .conv_start(conv_start), .conv_enable(conv_enable),
        .conv_irq(conv_irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        irq_seen = conv_irq;
        if (conv_irq) irq_count++;
    endtask

    task automatic idle();
        eoc_strobe = 0; eoc_result = '0; bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [15:0] exp, input string tag);
        bus_rd = 1; bus_addr = a; #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic wr_mode(input logic [7:0] d);
        bus_wr = 1; bus_addr = 2; bus_wdata = d;
        tick();
        idle();
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int c0;
        idle();
        rst_n = 0;
        repeat (3) tick();
        rst_n = 1;
        // R1 reset state
        chk("R1 irq", {15'd0, conv_irq}, 16'd0);
        chk("R1 start/enable", {14'd0, conv_start, conv_enable}, 16'd0);
        rd_chk(0, 16'd0, "R1 full");
        rd_chk(1, 16'd0, "R1 upper");
        rd_chk(2, 16'd0, "R1 mode");
        tick(); idle();

        // R4 mode readback over all codes
        for (int m = 0; m < 256; m++) begin
            wr_mode(8'(m));
            chk("R4 start", {15'd0, conv_start}, {15'd0, m[7]});
            chk("R4 enable", {15'd0, conv_enable}, {15'd0, m[0]});
            rd_chk(2, 16'(m), "R4 readback");
            tick(); idle();
        end
        wr_mode(8'h81);

        // R5 R2 R3 R11 sweep over every result value
        for (int v = 0; v < 1024; v++) begin
            eoc_strobe = 1; eoc_result = 10'(v);
            tick(); idle();
            chk("R5 irq after strobe", {15'd0, irq_seen}, 16'd1);
            rd_chk(0, 16'(v << 6), "R2 full view");
            tick(); idle();
            chk("R11 irq single cycle", {15'd0, irq_seen}, 16'd0);
            rd_chk(1, 16'(v >> 2), "R3 upper view");
            tick(); idle();
        end

        // R7 read collision: old value, deferred commit
        eoc_strobe = 1; eoc_result = 10'h155;
        rd_chk(0, 16'(1023 << 6), "R7 old value on clash");
        tick(); idle();
        chk("R7 no irq during read", {15'd0, irq_seen}, 16'd0);
        tick();
        chk("R7 irq after commit", {15'd0, irq_seen}, 16'd1);
        rd_chk(0, 16'(16'h155 << 6), "R7 committed value");
        tick(); idle();

        // R8 newer value replaces the deferred one, one interrupt
        c0 = irq_count;
        eoc_strobe = 1; eoc_result = 10'h0AA;
        rd_chk(1, 16'(16'h155 >> 2), "R8 read 1");
        tick();
        eoc_result = 10'h3C3;
        rd_chk(1, 16'(16'h155 >> 2), "R8 read 2");
        tick();
        eoc_strobe = 0;
        rd_chk(1, 16'(16'h155 >> 2), "R8 read 3");
        tick(); idle();
        repeat (3) tick();
        chk("R8 single irq", 16'(irq_count - c0), 16'd1);
        rd_chk(0, 16'(16'h3C3 << 6), "R8 newest value");
        tick(); idle();

        // R9 mode write collision drops the update
        c0 = irq_count;
        eoc_strobe = 1; eoc_result = 10'h001;
        bus_wr = 1; bus_addr = 2; bus_wdata = 8'h81;
        tick(); idle();
        repeat (2) tick();
        chk("R9 no irq", 16'(irq_count - c0), 16'd0);
        rd_chk(0, 16'(16'h3C3 << 6), "R9 result kept");
        tick(); idle();

        // R6 start bit clear ignores strobes
        wr_mode(8'h01);
        chk("R4 stopped outputs", {14'd0, conv_start, conv_enable}, 16'd1);
        c0 = irq_count;
        eoc_strobe = 1; eoc_result = 10'h002;
        tick(); idle();
        repeat (2) tick();
        chk("R6 no irq", 16'(irq_count - c0), 16'd0);
        rd_chk(0, 16'(16'h3C3 << 6), "R6 result kept");
        tick(); idle();

        // R10 writes to non-mode addresses are ignored
        for (int a = 0; a < 4; a++) begin
            if (a != 2) begin
                bus_wr = 1; bus_addr = 2'(a); bus_wdata = 8'hFE;
                tick(); idle();
            end
        end
        rd_chk(0, 16'(16'h3C3 << 6), "R10 result untouched");
        tick(); idle();
        rd_chk(2, 16'h0001, "R10 mode untouched");
        tick(); idle();
        rd_chk(3, 16'h0000, "R10 unused address");
        tick(); idle();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule